// File: doc/BRIEF.md
# Guarded Bypass Control Register File

This block is a small register file that decides whether a cipher datapath transforms data or passes it through untouched. Software talks to it over a single-cycle bus with an address, a write strobe with write data, and a read strobe whose data comes back one cycle later. The block drives a bypass flag to the datapath and a one-cycle re-enable event to a self-test controller, so that a known-answer test runs whenever encryption is switched back on.

After reset the block is in bypass. The first change of the enable state needs a preceding write of 1 to a permission register. Disabling encryption consumes that permission. Once encryption has been disabled, turning it back on is exempt from the permission check. Turning it off again always needs a fresh permission write.

Address map (ADDR_W-bit address): 0 is the read-only version word, 1 is the write-only permission register (bit 0), and 2 is the encrypt-enable register (bit 0, 1 means encrypt). Only bit 0 of write data is used.

Top module: `crypt_bypass_regs`

## Requirements
- R1: After reset, bypass_o is 1, reenable_o is 0 and rd_data_o is 0.
- R2: A register is written only in a cycle where wr_vld_i is 1. Address and data presented without the strobe change nothing.
- R3: A read strobe at address 0 returns the VERSION parameter on rd_data_o in the next cycle. At address 2 it returns the enable state in bit 0 with all other bits 0. At address 1 or any unmapped address it returns 0. In a cycle after no read strobe, rd_data_o is 0.
- R4: Before encryption has ever been disabled, a write of 1 to address 2 while permission is clear is ignored, and bypass_o stays 1.
- R5: Writing 1 to address 1 sets permission. A following write of 1 to address 2 clears bypass_o in the cycle after the write.
- R6: A write of 0 to address 2 while permission is clear is ignored, and encryption stays on.
- R7: A write of 0 to address 2 that disables encryption also clears permission. A further disable then needs a new permission write.
- R8: Once encryption has been disabled at least once, a write of 1 to address 2 re-enables it without a permission write.
- R9: reenable_o is 1 for exactly one cycle, the cycle in which bypass_o falls. It stays 0 on writes that leave the enable state unchanged.
- R10: Only bit 0 of wr_data_i is used. A permission write with bit 0 clear does not grant permission. An enable write with bit 0 clear is a disable request, whatever the upper bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wr_vld_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | DATA_W | Write data; only bit 0 is used |
| rd_vld_i | input | 1 | Read strobe, one cycle per read |
| rd_data_o | output | DATA_W | Read data, valid the cycle after the strobe, else 0 |
| bypass_o | output | 1 | 1 while the datapath passes data through |
| reenable_o | output | 1 | One-cycle pulse when encryption turns on |

## Verification
Enable writes are sent in four permission contexts: never granted, granted, granted and then consumed by a disable, and granted after a disable. This separates a gate that is missing or always open from one that never clears itself, and from one that also wrongly blocks re-enable. Writes with the strobe low and with only upper data bits set show whether the decode looks at the strobe and at bit 0 alone. Reads of every mapped address, the write-only address and an unmapped address, placed right after enable changes, check the one-cycle read latency and the read mux.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned ADDR_VERSION = 0;
  localparam int unsigned ADDR_PERM    = 1;
  localparam int unsigned ADDR_ENABLE  = 2;

  typedef struct packed {
    logic perm_wr;
    logic en_wr;
    logic rd_version;
    logic rd_enable;
  } sel_t;
endpackage

// File: rtl/cbr_decode.sv
module cbr_decode #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_vld_i,
  input  logic              rd_vld_i,
  output cbr_pkg::sel_t     sel_o
);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(cbr_pkg::ADDR_VERSION);
  localparam logic [ADDR_W-1:0] A_PERM = ADDR_W'(cbr_pkg::ADDR_PERM);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(cbr_pkg::ADDR_ENABLE);

  always_comb begin
    sel_o            = '0;
    sel_o.perm_wr    = wr_vld_i && (addr_i == A_PERM);
    sel_o.en_wr      = wr_vld_i && (addr_i == A_EN);
    sel_o.rd_version = rd_vld_i && (addr_i == A_VER);
    sel_o.rd_enable  = rd_vld_i && (addr_i == A_EN);
  end
endmodule

// File: rtl/cbr_enable_ctrl.sv
module cbr_enable_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic perm_wr_i,
  input  logic en_wr_i,
  input  logic wr_bit_i,
  output logic en_o,
  output logic perm_o,
  output logic reenable_o
);
  logic en_q, en_d;
  logic perm_q, perm_d;
  logic off_once_q, off_once_d;  // set by the first disable, exempts re-enable
  logic rise_q, rise_d;

  always_comb begin
    en_d       = en_q;
    perm_d     = perm_q;
    off_once_d = off_once_q;
    rise_d     = 1'b0;
    if (perm_wr_i) perm_d = wr_bit_i;
    if (en_wr_i) begin
      if (wr_bit_i && !en_q && (perm_q || off_once_q)) begin
        en_d   = 1'b1;
        rise_d = 1'b1;
      end else if (!wr_bit_i && en_q && perm_q) begin
        en_d       = 1'b0;
        perm_d     = 1'b0;
        off_once_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      perm_q     <= 1'b0;
      off_once_q <= 1'b0;
      rise_q     <= 1'b0;
    end else begin
      en_q       <= en_d;
      perm_q     <= perm_d;
      off_once_q <= off_once_d;
      rise_q     <= rise_d;
    end
  end

  assign en_o       = en_q;
  assign perm_o     = perm_q;
  assign reenable_o = rise_q;
endmodule

// File: rtl/cbr_read_port.sv
module cbr_read_port #(
  parameter int unsigned          DATA_W  = 32,
  parameter logic [DATA_W-1:0]    VERSION = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_version_i,
  input  logic              rd_enable_i,
  input  logic              en_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned PAD_W = DATA_W - 1;

  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    if (rd_version_i)     rd_d = VERSION;
    else if (rd_enable_i) rd_d = {{PAD_W{1'b0}}, en_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/crypt_bypass_regs.sv
module crypt_bypass_regs #(
  parameter int unsigned       ADDR_W  = 4,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = DATA_W'(32'h0002_0105)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_vld_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_vld_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              bypass_o,
  output logic              reenable_o
);
  cbr_pkg::sel_t sel;
  logic          en;
  logic          perm;

  cbr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i  (addr_i),
    .wr_vld_i(wr_vld_i),
    .rd_vld_i(rd_vld_i),
    .sel_o   (sel)
  );

  cbr_enable_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .perm_wr_i (sel.perm_wr),
    .en_wr_i   (sel.en_wr),
    .wr_bit_i  (wr_data_i[0]),
    .en_o      (en),
    .perm_o    (perm),
    .reenable_o(reenable_o)
  );

  cbr_read_port #(.DATA_W(DATA_W), .VERSION(VERSION)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_version_i(sel.rd_version),
    .rd_enable_i (sel.rd_enable),
    .en_i        (en),
    .rd_data_o   (rd_data_o)
  );

  assign bypass_o = ~en;
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int unsigned       ADDR_W  = 4,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_vld_i,
  input logic              rd_vld_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              bypass_o,
  input logic              reenable_o,
  input logic              perm
);
  localparam logic [ADDR_W-1:0] A_VER = ADDR_W'(cbr_pkg::ADDR_VERSION);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(cbr_pkg::ADDR_ENABLE);

  assert_ver_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_vld_i && addr_i == A_VER) |=> (rd_data_o == VERSION));

  assert_idle_read_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_vld_i |=> (rd_data_o == '0));

  assert_bypass_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bypass_o) |-> ($past(wr_vld_i) && $past(addr_i) == A_EN));

  assert_disable_clears_perm_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bypass_o) |-> !perm);

  assert_pulse_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bypass_o) |-> reenable_o);

  assert_pulse_only_on_fall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reenable_o |-> (!bypass_o && $past(bypass_o)));

  assert_pulse_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reenable_o |=> !reenable_o);
endmodule

bind crypt_bypass_regs cbr_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .VERSION(VERSION)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_vld_i  (wr_vld_i),
  .rd_vld_i  (rd_vld_i),
  .rd_data_o (rd_data_o),
  .bypass_o  (bypass_o),
  .reenable_o(reenable_o),
  .perm      (perm)
);

// File: tb/sim_crypt_bypass_regs.sv
`timescale 1ns/1ps
module sim_crypt_bypass_regs;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 32;
  localparam logic [DATA_W-1:0] VER = 32'h0002_0105;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_vld = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_vld = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              bypass;
  logic              reen;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              pend = 1'b0;

  always #2.5 clk = ~clk;

  crypt_bypass_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VER)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_vld_i(wr_vld),
    .wr_data_i(wr_data), .rd_vld_i(rd_vld), .rd_data_o(rd_data),
    .bypass_o(bypass), .reenable_o(reen)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops expected read data in the cycle after each strobe.
  always @(posedge clk) pend <= rd_vld;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend) begin
        if (exp_q.size() == 0) chk("R3 unexpected read", 1, 0);
        else chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end else begin
        chk("R3 idle read data", rd_data, '0);
      end
    end
  end

  task automatic wr(input int unsigned a, input logic [DATA_W-1:0] d);
    addr = ADDR_W'(a); wr_data = d; wr_vld = 1'b1;
    @(negedge clk);
    wr_vld = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int unsigned a, input logic [DATA_W-1:0] e, input string tag);
    addr = ADDR_W'(a); rd_vld = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_vld = 1'b0;
  endtask

  task automatic state(input string req, input logic byp, input logic pulse);
    chk({req, " bypass"}, DATA_W'(bypass), DATA_W'(byp));
    chk({req, " reenable"}, DATA_W'(reen), DATA_W'(pulse));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    state("R1", 1'b1, 1'b0);
    chk("R1 rd_data", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 read map
    rd(0, VER, "R3 version");
    rd(2, 32'h0, "R3 enable off");
    rd(1, 32'h0, "R3 write-only addr");
    rd(7, 32'h0, "R3 unmapped addr");
    // R4 enable without permission
    wr(2, 32'h1);
    state("R4", 1'b1, 1'b0);
    rd(2, 32'h0, "R4 enable readback");
    // R2 no strobe: permission not granted
    addr = 4'd1; wr_data = 32'h1;
    @(negedge clk);
    wr(2, 32'h1);
    state("R2", 1'b1, 1'b0);
    // R10 permission with bit0 clear
    wr(1, 32'hFFFF_FFFE);
    wr(2, 32'h1);
    state("R10 perm bit0", 1'b1, 1'b0);
    // R5 granted enable, R9 pulse
    wr(1, 32'h1);
    wr(2, 32'h1);
    state("R5 R9 enable", 1'b0, 1'b1);
    @(negedge clk);
    state("R9 pulse end", 1'b0, 1'b0);
    rd(2, 32'h1, "R5 enable readback");
    // R9 same-value write
    wr(2, 32'h1);
    state("R9 no change", 1'b0, 1'b0);
    // disable with permission still held
    wr(2, 32'h0);
    state("R7 disable", 1'b1, 1'b0);
    rd(2, 32'h0, "R7 readback");
    // R8 re-enable without permission
    wr(2, 32'h1);
    state("R8 re-enable", 1'b0, 1'b1);
    rd(2, 32'h1, "R8 readback");
    // R6 / R7 disable now blocked: permission was consumed
    wr(2, 32'h0);
    state("R6 R7 blocked disable", 1'b0, 1'b0);
    // R10 disable with upper bits set
    wr(1, 32'h1);
    wr(2, 32'hFFFF_FFFE);
    state("R10 disable bit0", 1'b1, 1'b0);
    rd(0, VER, "R3 version again");
    repeat (3) @(negedge clk);
    chk("R3 queue drained", DATA_W'(exp_q.size()), '0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule